// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between a CPU's 16-bit address bus and the memories and register blocks behind it. For each address it works out which target is addressed: cartridge ROM (fixed or switched window), cartridge RAM, video RAM, work RAM, object memory, I/O, or high RAM. It drives a one-hot select and a local offset for that target. For work RAM it also reports which 4 KiB bank the access uses. The targets return their read bytes on one packed bus, and the block steers the addressed byte back to the CPU.

Video RAM and object memory are shared with a display engine. Whether the CPU may reach them depends on the current video mode. A blocked access selects no target, forwards no write, and reads back the open-bus value 0xFF. The same applies to the unusable gap and to fixed-ROM addresses beyond the configured ROM size. The block holds two pieces of state. One is the switchable work-RAM bank register, which has its own write port. The other is the interrupt-enable byte at the top of the address space.

Top module: `memmap_decoder`

## Requirements
- R1: The work-RAM bank register is 3 bits wide and is loaded from `bank_wdata` one clock after `bank_wr`. A written 0 is stored as 1. The register comes out of reset holding 1.
- R2: Addresses 0xC000–0xCFFF select work RAM with `wram_bank` = 0. Addresses 0xD000–0xDFFF select work RAM with `wram_bank` equal to the bank register. In both ranges the offset is `addr[11:0]`. Outside the work-RAM ranges `wram_bank` is 0.
- R3: Addresses 0xE000–0xEFFF behave exactly like 0xC000–0xCFFF. Addresses 0xF000–0xFDFF behave exactly like the matching 0xD000-based address, with offset `addr[11:0]`.
- R4: Addresses 0x8000–0x9FFF select video RAM with offset `addr[12:0]`. In video mode 3 the access is blocked: no select, no write strobe, and a read value of 0xFF.
- R5: Addresses 0xFE00–0xFE9F select object memory with offset `addr[7:0]`, but only in video modes 0 and 1. In modes 2 and 3 the access is blocked in the same way as R4.
- R6: Addresses 0xFEA0–0xFEFF select nothing, never raise the write strobe, read 0xFF, and drive offset 0.
- R7: Addresses 0xFF00–0xFF7F select I/O and addresses 0xFF80–0xFFFE select high RAM, each with offset `addr[6:0]`. Address 0xFFFF is an internal interrupt-enable byte. It reads 0 after reset, is written by a CPU write one clock later, selects no target, and drives offset 0.
- R8: Addresses 0x0000–0x3FFF select fixed ROM with offset `addr[13:0]`, but only when `addr[13:0]` < `rom_top`. At or beyond `rom_top` the access is blocked in the same way as R4. Addresses 0x4000–0x7FFF select the switched ROM window with offset `addr[13:0]`. Addresses 0xA000–0xBFFF select cartridge RAM with offset `addr[12:0]`.
- R9: Target codes are fixed ROM 0, switched ROM 1, video RAM 2, cartridge RAM 3, work RAM 4, object memory 5, I/O 6 and high RAM 7. Select bit i, and read lane `tgt_rdata[8*i+7:8*i]`, belong to target i. At most one select bit is high. A permitted access returns its target's lane on `cpu_rdata`.
- R10: Select bits are high only while `cpu_rd` or `cpu_wr` is high. `tgt_wr` is high only for a permitted write to a target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_wdata | input | 8 | CPU write data (used by the interrupt-enable byte) |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| bank_wr | input | 1 | Load the work-RAM bank register |
| bank_wdata | input | 3 | New work-RAM bank number |
| vmode | input | 2 | Current video mode, 0 to 3 |
| rom_top | input | 15 | Number of fixed-ROM bytes present (0 to 16384) |
| tgt_rdata | input | 64 | Packed read bytes from the eight targets, lane i for target i |
| tgt_sel | output | 8 | One-hot target select |
| tgt_off | output | 14 | Local offset within the target |
| wram_bank | output | 3 | Work-RAM bank used by the current access |
| tgt_wr | output | 1 | Write strobe to the selected target |

## Verification
The bank register and the interrupt-enable byte are the only state. A bad bank register therefore shows up only on `wram_bank` for 0xD000–0xDFFF and 0xF000–0xFDFF accesses. It is seen in the first such access after the faulty load: a write of 0 that is not turned into 1 shows up one clock after `bank_wr`. A bad interrupt-enable byte shows up on the next read of 0xFFFF. Decode and gating faults are combinational and appear on the selects, offset or read data in the same cycle as the address. The bench therefore mixes random addresses, biased toward the crowded 0xF000 page, with directed accesses at every range boundary and in every video mode.

// File: rtl/memmap_pkg.sv
// Shared region and target codes for the memory map decoder.
// Assumes an eight-target layout; target codes index select bits and read lanes.
package memmap_pkg;

    localparam int NTGT  = 8;
    localparam int TGT_W = $clog2(NTGT);

    typedef enum logic [3:0] {
        RG_ROM0, RG_ROMX, RG_VRAM, RG_XRAM, RG_WRAM0, RG_WRAMX,
        RG_OAM, RG_GAP, RG_IO, RG_HRAM, RG_IE
    } region_e;

    localparam logic [TGT_W-1:0] TG_ROM0 = 3'd0;
    localparam logic [TGT_W-1:0] TG_ROMX = 3'd1;
    localparam logic [TGT_W-1:0] TG_VRAM = 3'd2;
    localparam logic [TGT_W-1:0] TG_XRAM = 3'd3;
    localparam logic [TGT_W-1:0] TG_WRAM = 3'd4;
    localparam logic [TGT_W-1:0] TG_OAM  = 3'd5;
    localparam logic [TGT_W-1:0] TG_IO   = 3'd6;
    localparam logic [TGT_W-1:0] TG_HRAM = 3'd7;

    // Map a region to its target code; gap and interrupt-enable have none.
    function automatic logic [TGT_W-1:0] region_target(region_e r);
        case (r)
            RG_ROM0:           return TG_ROM0;
            RG_ROMX:           return TG_ROMX;
            RG_VRAM:           return TG_VRAM;
            RG_XRAM:           return TG_XRAM;
            RG_WRAM0, RG_WRAMX: return TG_WRAM;
            RG_OAM:            return TG_OAM;
            RG_IO:             return TG_IO;
            RG_HRAM:           return TG_HRAM;
            default:           return '0;
        endcase
    endfunction

    function automatic logic region_has_target(region_e r);
        return (r != RG_GAP) && (r != RG_IE);
    endfunction

endpackage

// File: rtl/memmap_region_decode.sv
// Address classifier: turns a 16-bit CPU address into a region code and a
// local offset. Purely combinational; assumes OFF_W >= 14.
module memmap_region_decode
    import memmap_pkg::*;
#(
    parameter int OFF_W = 14
) (
    input  logic [15:0]      addr,
    output region_e          region,
    output logic [OFF_W-1:0] offset
);

    // Decode the top nibble, then split the last page by its low bits.
    always_comb begin
        region = RG_GAP;
        offset = '0;
        case (addr[15:12])
            4'h0, 4'h1, 4'h2, 4'h3: begin
                region = RG_ROM0;
                offset = OFF_W'(addr[13:0]);
            end
            4'h4, 4'h5, 4'h6, 4'h7: begin
                region = RG_ROMX;
                offset = OFF_W'(addr[13:0]);
            end
            4'h8, 4'h9: begin
                region = RG_VRAM;
                offset = OFF_W'(addr[12:0]);
            end
            4'hA, 4'hB: begin
                region = RG_XRAM;
                offset = OFF_W'(addr[12:0]);
            end
            4'hC, 4'hE: begin
                region = RG_WRAM0;
                offset = OFF_W'(addr[11:0]);
            end
            4'hD: begin
                region = RG_WRAMX;
                offset = OFF_W'(addr[11:0]);
            end
            default: begin
                if (addr[11:9] != 3'b111) begin
                    region = RG_WRAMX;
                    offset = OFF_W'(addr[11:0]);
                end else if (!addr[8]) begin
                    if (addr[7:0] < 8'hA0) begin
                        region = RG_OAM;
                        offset = OFF_W'(addr[7:0]);
                    end else begin
                        region = RG_GAP;
                    end
                end else if (!addr[7]) begin
                    region = RG_IO;
                    offset = OFF_W'(addr[6:0]);
                end else if (addr[6:0] != 7'h7F) begin
                    region = RG_HRAM;
                    offset = OFF_W'(addr[6:0]);
                end else begin
                    region = RG_IE;
                end
            end
        endcase
    end

endmodule

// File: rtl/memmap_access_gate.sv
// Permission check: decides whether the decoded region may be touched now,
// given the video mode and the fixed-ROM size. Assumes vmode is 0..3.
module memmap_access_gate
    import memmap_pkg::*;
#(
    parameter int OFF_W = 14
) (
    input  region_e          region,
    input  logic [OFF_W-1:0] offset,
    input  logic [1:0]       vmode,
    input  logic [OFF_W:0]   rom_top,
    output logic             allow
);

    // Blocked: video RAM in mode 3, object memory in modes 2-3, ROM past its size, gap.
    always_comb begin
        case (region)
            RG_VRAM: allow = (vmode != 2'd3);
            RG_OAM:  allow = !vmode[1];
            RG_ROM0: allow = ({1'b0, offset} < rom_top);
            RG_GAP:  allow = 1'b0;
            RG_IE:   allow = 1'b0;
            default: allow = 1'b1;
        endcase
    end

endmodule

// File: rtl/memmap_bank_reg.sv
// Switchable work-RAM bank register. A written 0 is stored as 1, so the
// switched half never aliases bank 0. Synchronous active-low reset to 1.
module memmap_bank_reg #(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] bank_q
);

    // Load the bank number, promoting 0 to 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= BANK_W'(1);
        else if (wr)
            bank_q <= (wdata == '0) ? BANK_W'(1) : wdata;
    end

endmodule

// File: rtl/memmap_rdata_mux.sv
// Read-data steering: returns the addressed target's lane, the
// interrupt-enable byte, or the open-bus value when the access is blocked.
module memmap_rdata_mux #(
    parameter int NT     = 8,
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(NT)
) (
    input  logic [NT*DATA_W-1:0] lanes,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 hit,
    input  logic                 is_ie,
    input  logic [DATA_W-1:0]    ie_val,
    output logic [DATA_W-1:0]    rdata
);

    logic [DATA_W-1:0] lane_arr [NT];

    for (genvar i = 0; i < NT; i++) begin : g_lane
        assign lane_arr[i] = lanes[i*DATA_W +: DATA_W];
    end

    // Pick the lane, the internal byte, or all ones.
    always_comb begin
        if (hit)
            rdata = lane_arr[idx];
        else if (is_ie)
            rdata = ie_val;
        else
            rdata = '1;
    end

endmodule

// File: rtl/memmap_decoder.sv
// Banked memory map decoder top. Classifies the CPU address, applies video
// mode and ROM-size gating, drives one-hot selects, offset and bank, and
// steers read data back. State: work-RAM bank register and interrupt-enable byte.
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BANK_W = 3,
    parameter int OFF_W  = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [15:0]            cpu_addr,
    input  logic                   cpu_rd,
    input  logic                   cpu_wr,
    input  logic [DATA_W-1:0]      cpu_wdata,
    output logic [DATA_W-1:0]      cpu_rdata,
    input  logic                   bank_wr,
    input  logic [BANK_W-1:0]      bank_wdata,
    input  logic [1:0]             vmode,
    input  logic [OFF_W:0]         rom_top,
    input  logic [NTGT*DATA_W-1:0] tgt_rdata,
    output logic [NTGT-1:0]        tgt_sel,
    output logic [OFF_W-1:0]       tgt_off,
    output logic [BANK_W-1:0]      wram_bank,
    output logic                   tgt_wr
);

    region_e           region;
    logic [OFF_W-1:0]  offset;
    logic              allow;
    logic [TGT_W-1:0]  tidx;
    logic              hit;
    logic              is_ie;
    logic              access;
    logic [BANK_W-1:0] bank_q;
    logic [DATA_W-1:0] ie_q;

    memmap_region_decode #(.OFF_W(OFF_W)) u_decode (
        .addr   (cpu_addr),
        .region (region),
        .offset (offset)
    );

    memmap_access_gate #(.OFF_W(OFF_W)) u_gate (
        .region  (region),
        .offset  (offset),
        .vmode   (vmode),
        .rom_top (rom_top),
        .allow   (allow)
    );

    memmap_bank_reg #(.BANK_W(BANK_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bank_wr),
        .wdata  (bank_wdata),
        .bank_q (bank_q)
    );

    assign tidx   = region_target(region);
    assign hit    = allow && region_has_target(region);
    assign is_ie  = (region == RG_IE);
    assign access = cpu_rd || cpu_wr;

    // Interrupt-enable byte: cleared by reset, loaded by a CPU write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ie_q <= '0;
        else if (cpu_wr && is_ie)
            ie_q <= cpu_wdata;
    end

    for (genvar i = 0; i < NTGT; i++) begin : g_sel
        assign tgt_sel[i] = access && hit && (tidx == TGT_W'(i));
    end

    assign tgt_off = offset;
    assign tgt_wr  = cpu_wr && hit;

    // Bank shown to work RAM: 0 for the fixed half, the register for the switched half.
    always_comb begin
        case (region)
            RG_WRAMX: wram_bank = bank_q;
            default:  wram_bank = '0;
        endcase
    end

    memmap_rdata_mux #(.NT(NTGT), .DATA_W(DATA_W)) u_mux (
        .lanes  (tgt_rdata),
        .idx    (tidx),
        .hit    (hit),
        .is_ie  (is_ie),
        .ie_val (ie_q),
        .rdata  (cpu_rdata)
    );

endmodule

// File: rtl/memmap_checker.sv
// Property checker for the memory map decoder, attached with bind.
// Observes ports plus the bank register and interrupt-enable byte.
module memmap_checker #(
    parameter int DATA_W = 8,
    parameter int BANK_W = 3,
    parameter int NT     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              bank_wr,
    input logic [BANK_W-1:0] bank_wdata,
    input logic [1:0]        vmode,
    input logic [NT-1:0]     tgt_sel,
    input logic              tgt_wr,
    input logic [BANK_W-1:0] bank_q,
    input logic [DATA_W-1:0] ie_q
);

    logic in_vram, in_oam, in_gap;
    assign in_vram = (cpu_addr[15:13] == 3'b100);
    assign in_oam  = (cpu_addr >= 16'hFE00) && (cpu_addr <= 16'hFE9F);
    assign in_gap  = (cpu_addr >= 16'hFEA0) && (cpu_addr <= 16'hFEFF);

    assert_bank_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_wr && bank_wdata == '0) |=> (bank_q == BANK_W'(1)));

    assert_bank_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_wr && bank_wdata != '0) |=> (bank_q == $past(bank_wdata)));

    assert_bank_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_wr |=> $stable(bank_q));

    assert_vram_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vram && vmode == 2'd3) |-> (tgt_sel == '0 && !tgt_wr && cpu_rdata == '1));

    assert_oam_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_oam && vmode[1]) |-> (tgt_sel == '0 && !tgt_wr && cpu_rdata == '1));

    assert_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_gap |-> (tgt_sel == '0 && !tgt_wr && cpu_rdata == '1));

    assert_ie_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 16'hFFFF) |=> (ie_q == $past(cpu_wdata)));

    assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_sel));

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd && !cpu_wr) |-> (tgt_sel == '0));

    assert_wr_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_wr |-> (cpu_wr && $countones(tgt_sel) == 1));

endmodule

bind memmap_decoder memmap_checker #(
    .DATA_W (DATA_W),
    .BANK_W (BANK_W),
    .NT     (memmap_pkg::NTGT)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .cpu_wdata  (cpu_wdata),
    .cpu_rdata  (cpu_rdata),
    .bank_wr    (bank_wr),
    .bank_wdata (bank_wdata),
    .vmode      (vmode),
    .tgt_sel    (tgt_sel),
    .tgt_wr     (tgt_wr),
    .bank_q     (bank_q),
    .ie_q       (ie_q)
);

// File: tb/memmap_decoder_test.sv
// Self-checking bench: directed boundaries plus seeded random accesses,
// compared against a reference model written from the requirements.
module memmap_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic        cpu_rd, cpu_wr;
    logic [7:0]  cpu_wdata, cpu_rdata;
    logic        bank_wr;
    logic [2:0]  bank_wdata;
    logic [1:0]  vmode;
    logic [14:0] rom_top;
    logic [63:0] tgt_rdata;
    logic [7:0]  tgt_sel;
    logic [13:0] tgt_off;
    logic [2:0]  wram_bank;
    logic        tgt_wr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [2:0] bank_m;
    logic [7:0] ie_m;

    always #5 clk = ~clk;

    memmap_decoder uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .bank_wr(bank_wr), .bank_wdata(bank_wdata), .vmode(vmode),
        .rom_top(rom_top), .tgt_rdata(tgt_rdata), .tgt_sel(tgt_sel),
        .tgt_off(tgt_off), .wram_bank(wram_bank), .tgt_wr(tgt_wr)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s addr=%h actual=%h expected=%h", tag, what, cpu_addr, act, exp);
        end
    endtask

    // Reference model of one access, from R2..R10.
    task automatic model(input logic [15:0] a, input logic [1:0] vm, input logic rd,
                         input logic wr, input logic [14:0] rt,
                         output logic [7:0] esel, output logic [13:0] eoff,
                         output logic [2:0] ebank, output logic [7:0] erd,
                         output logic ewr, output string tag);
        int  t  = -1;
        bit  ok = 1'b1;
        eoff = '0; ebank = '0;
        if (a < 16'h4000) begin
            t = 0; eoff = a[13:0]; ok = ({1'b0, a[13:0]} < rt); tag = "R8";
        end else if (a < 16'h8000) begin
            t = 1; eoff = a[13:0]; tag = "R8";
        end else if (a < 16'hA000) begin
            t = 2; eoff = {1'b0, a[12:0]}; ok = (vm != 2'd3); tag = "R4";
        end else if (a < 16'hC000) begin
            t = 3; eoff = {1'b0, a[12:0]}; tag = "R8";
        end else if (a < 16'hD000 || (a >= 16'hE000 && a < 16'hF000)) begin
            t = 4; eoff = {2'b0, a[11:0]}; ebank = 3'd0; tag = (a < 16'hE000) ? "R2" : "R3";
        end else if (a < 16'hFE00) begin
            t = 4; eoff = {2'b0, a[11:0]}; ebank = bank_m; tag = (a < 16'hE000) ? "R2" : "R3";
        end else if (a < 16'hFEA0) begin
            t = 5; eoff = {6'b0, a[7:0]}; ok = !vm[1]; tag = "R5";
        end else if (a < 16'hFF00) begin
            ok = 1'b0; tag = "R6";
        end else if (a < 16'hFF80) begin
            t = 6; eoff = {7'b0, a[6:0]}; tag = "R7";
        end else if (a < 16'hFFFF) begin
            t = 7; eoff = {7'b0, a[6:0]}; tag = "R7";
        end else begin
            ok = 1'b0; tag = "R7";
        end
        if (t >= 0 && ok) erd = tgt_rdata[t*8 +: 8];
        else if (a == 16'hFFFF) erd = ie_m;
        else erd = 8'hFF;
        esel = ((rd || wr) && ok && t >= 0) ? (8'd1 << t) : 8'd0;
        ewr  = wr && ok && (t >= 0);
    endtask

    // Drive one access away from the edge, check outputs, then advance the model.
    task automatic access(input logic [15:0] a, input logic [1:0] vm, input logic rd,
                          input logic wr, input logic [7:0] wd, input logic [14:0] rt,
                          input logic bw, input logic [2:0] bd);
        logic [7:0] esel, erd; logic [13:0] eoff; logic [2:0] ebank; logic ewr; string tag;
        @(negedge clk);
        cpu_addr = a; vmode = vm; cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd;
        rom_top = rt; bank_wr = bw; bank_wdata = bd;
        tgt_rdata = {$urandom, $urandom};
        #1;
        model(a, vm, rd, wr, rt, esel, eoff, ebank, erd, ewr, tag);
        check(tag, "tgt_sel R9 R10", 32'(tgt_sel), 32'(esel));
        check(tag, "tgt_off", 32'(tgt_off), 32'(eoff));
        check(tag, "wram_bank", 32'(wram_bank), 32'(ebank));
        check(tag, "cpu_rdata R9", 32'(cpu_rdata), 32'(erd));
        check(tag, "tgt_wr R10", 32'(tgt_wr), 32'(ewr));
        if (bw) bank_m = (bd == 3'd0) ? 3'd1 : bd;
        if (wr && a == 16'hFFFF) ie_m = wd;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cpu_addr = '0; cpu_rd = 0; cpu_wr = 0; cpu_wdata = '0;
        bank_wr = 0; bank_wdata = '0; vmode = '0; rom_top = 15'd16384; tgt_rdata = '0;
        bank_m = 3'd1; ie_m = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // Reset state: bank 1 (R1), interrupt-enable 0 (R7)
        access(16'hD123, 2'd0, 1, 0, 8'h00, 15'd16384, 0, 3'd0);
        check("R1", "reset bank", 32'(wram_bank), 32'd1);
        access(16'hFFFF, 2'd0, 1, 0, 8'h00, 15'd16384, 0, 3'd0);
        check("R7", "reset ie", 32'(cpu_rdata), 32'd0);

        // R1: write 5, then 0 becomes 1, then 7
        access(16'h0000, 2'd0, 0, 0, 8'h00, 15'd16384, 1, 3'd5);
        access(16'hDFFF, 2'd0, 1, 0, 8'h00, 15'd16384, 1, 3'd0);
        check("R1", "bank 5", 32'(wram_bank), 32'd5);
        access(16'hF000, 2'd1, 0, 1, 8'h00, 15'd16384, 1, 3'd7);
        check("R1", "zero->1", 32'(wram_bank), 32'd1);
        access(16'hFDFF, 2'd0, 1, 0, 8'h00, 15'd16384, 0, 3'd0);
        check("R3", "echo bank 7", 32'(wram_bank), 32'd7);

        // R2/R3 edges
        access(16'hCFFF, 2'd0, 1, 0, 8'h00, 15'd16384, 0, 3'd0);
        access(16'hEFFF, 2'd0, 1, 0, 8'h00, 15'd16384, 0, 3'd0);
        access(16'hE000, 2'd3, 0, 1, 8'h00, 15'd16384, 0, 3'd0);

        // R4 video RAM in every mode
        for (int m = 0; m < 4; m++) begin
            access(16'h8000, 2'(m), 1, 0, 8'h00, 15'd16384, 0, 3'd0);
            access(16'h9FFF, 2'(m), 0, 1, 8'h00, 15'd16384, 0, 3'd0);
            access(16'hFE00, 2'(m), 1, 0, 8'h00, 15'd16384, 0, 3'd0);
            access(16'hFE9F, 2'(m), 0, 1, 8'h00, 15'd16384, 0, 3'd0);
            access(16'hFEA0, 2'(m), 1, 1, 8'h00, 15'd16384, 0, 3'd0);
        end
        access(16'hFEFF, 2'd0, 1, 0, 8'h00, 15'd16384, 0, 3'd0);
        check("R6", "gap read", 32'(cpu_rdata), 32'hFF);

        // R7 boundaries and interrupt-enable write-back
        access(16'hFF7F, 2'd0, 1, 0, 8'h00, 15'd16384, 0, 3'd0);
        access(16'hFF80, 2'd0, 1, 0, 8'h00, 15'd16384, 0, 3'd0);
        access(16'hFFFE, 2'd0, 0, 1, 8'h00, 15'd16384, 0, 3'd0);
        access(16'hFFFF, 2'd0, 0, 1, 8'h5A, 15'd16384, 0, 3'd0);
        access(16'hFFFF, 2'd0, 1, 0, 8'h00, 15'd16384, 0, 3'd0);
        check("R7", "ie readback", 32'(cpu_rdata), 32'h5A);

        // R8 ROM size edge
        access(16'h1FFF, 2'd0, 1, 0, 8'h00, 15'h2000, 0, 3'd0);
        access(16'h2000, 2'd0, 1, 0, 8'h00, 15'h2000, 0, 3'd0);
        check("R8", "rom beyond size", 32'(cpu_rdata), 32'hFF);
        access(16'h3FFF, 2'd0, 1, 0, 8'h00, 15'd0, 0, 3'd0);
        access(16'h4000, 2'd0, 1, 0, 8'h00, 15'd0, 0, 3'd0);
        access(16'hBFFF, 2'd3, 0, 1, 8'h00, 15'd0, 0, 3'd0);

        // R10 idle cycle
        access(16'hC000, 2'd0, 0, 0, 8'h00, 15'd16384, 0, 3'd0);

        // Random mix, biased to the last page
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            a = ($urandom % 2) ? 16'($urandom) : {4'hF, 12'($urandom)};
            access(a, 2'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
                   15'($urandom_range(0, 16384)), ($urandom % 8) == 0, 3'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule